// File: doc/BRIEF.md
# Select-Coded 4-Bit Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit with two 4-bit operands, a carry input and a 3-bit operation select. A single ripple carry chain serves three arithmetic codes: sum, operand B less operand A, and operand A less operand B. Three further codes give bitwise exclusive-or, inclusive-or and and, one code clears the result, and one code sets every result bit.

A subtraction is formed as the minuend plus the bit-inverted subtrahend plus the carry input. A caller who wants a true two's-complement difference therefore sets the carry input to 1. The carry out and the signed overflow flag carry meaning only for the three arithmetic codes. For every other code both flags are held at 0, so a caller can sample them without first decoding the select.

Top module: `alu4`

## Requirements
- R1: With sel=000 the result is 0000, and carry out and overflow are 0 for any operands and carry input.
- R2: With sel=011 the outputs {cout,f} equal a + b + cin, taken as a 5-bit unsigned sum.
- R3: With sel=001 the outputs {cout,f} equal b + (~a) + cin, so cin=1 gives b minus a.
- R4: With sel=010 the outputs {cout,f} equal a + (~b) + cin, so cin=1 gives a minus b.
- R5: For the arithmetic codes (001, 010, 011) the overflow flag is the carry out of bit 3 XOR the carry into bit 3. This flag is 1 exactly when both adder inputs have the same sign and the result sign differs from it.
- R6: With sel=100 the result is a XOR b. With b=1111 this gives the complement of a, and with equal operands it gives 0000.
- R7: With sel=101 the result is a OR b.
- R8: With sel=110 the result is a AND b.
- R9: With sel=111 the result is 1111.
- R10: For sel values 000, 100, 101, 110 and 111, carry out and overflow are 0 and cin has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| cin | input | 1 | Carry into bit 0 |
| sel | input | 3 | Operation select |
| f | output | 4 | Result |
| cout | output | 1 | Carry out of bit 3 (arithmetic codes only) |
| ovr | output | 1 | Signed overflow (arithmetic codes only) |

## Verification
The bound checker tests the following whenever the inputs change: the flag masking for non-arithmetic codes, the clear and preset values, the exclusive-or result, the full add relation, and the sign-based form of overflow. The checker states overflow in terms of operand and result signs, which is a different formulation from the carry-pair rule in the design. Only the bench scenarios show that both subtraction orders pick the right minuend and that cin=0 yields a ones'-complement difference. The same holds for the boundary sums at -8 and -1, and for cin having no effect under the logic codes, which the bench sweeps over every operand pair.

// File: rtl/alu4.sv
module alu4 #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   sel,
  output logic [W-1:0] f,
  output logic         cout,
  output logic         ovr
);
  localparam logic [2:0] OP_CLR = 3'b000;
  localparam logic [2:0] OP_BMA = 3'b001;
  localparam logic [2:0] OP_AMB = 3'b010;
  localparam logic [2:0] OP_ADD = 3'b011;
  localparam logic [2:0] OP_XOR = 3'b100;
  localparam logic [2:0] OP_OR  = 3'b101;
  localparam logic [2:0] OP_AND = 3'b110;

  logic [W-1:0] x, y, s;
  logic [W:0]   c;
  logic         arith;

  assign arith = (sel == OP_ADD) || (sel == OP_BMA) || (sel == OP_AMB);
  assign x     = (sel == OP_BMA) ? b : a;
  assign y     = (sel == OP_BMA) ? ~a : (sel == OP_AMB) ? ~b : b;
  assign c[0]  = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
  end

  always_comb begin
    case (sel)
      OP_CLR:                 f = '0;
      OP_BMA, OP_AMB, OP_ADD: f = s;
      OP_XOR:                 f = a ^ b;
      OP_OR:                  f = a | b;
      OP_AND:                 f = a & b;
      default:                f = '1;
    endcase
  end

  assign cout = arith & c[W];
  assign ovr  = arith & (c[W] ^ c[W-1]);
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [2:0]   sel,
  input logic [W-1:0] f,
  input logic         cout,
  input logic         ovr
);
  logic         is_arith;
  logic         xs, ys;
  logic [W:0]   add_ref;

  assign is_arith = (sel == 3'b001) || (sel == 3'b010) || (sel == 3'b011);
  assign xs       = (sel == 3'b001) ? b[W-1] : a[W-1];
  assign ys       = (sel == 3'b001) ? ~a[W-1] : (sel == 3'b010) ? ~b[W-1] : b[W-1];
  assign add_ref  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    if (!is_arith) a_r10_flags_low: assert (!cout && !ovr);
    if (sel == 3'b000) a_r1_clear: assert (f == '0);
    if (sel == 3'b111) a_r9_preset: assert (f == '1);
    if (sel == 3'b100) a_r6_xor: assert (f == (a ^ b));
    if (sel == 3'b011) a_r2_add: assert ({cout, f} == add_ref);
    if (is_arith) a_r5_overflow: assert (ovr == ((xs == ys) && (f[W-1] != xs)));
  end
endmodule

bind alu4 alu4_chk #(.W(W)) chk (.*);

// File: tb/alu4_test.sv
module alu4_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [2:0] sel = '0;
  logic [3:0] f;
  logic       cout, ovr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  alu4 uut (.a(a), .b(b), .cin(cin), .sel(sel), .f(f), .cout(cout), .ovr(ovr));

  // {sel, a, b, cin, f, cout, ovr}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {3'b000, 4'b1010, 4'b0101, 1'b1, 4'b0000, 1'b0, 1'b0},
    {3'b011, 4'b0110, 4'b0011, 1'b0, 4'b1001, 1'b0, 1'b1},
    {3'b001, 4'b0110, 4'b0011, 1'b1, 4'b1101, 1'b0, 1'b0},
    {3'b010, 4'b0110, 4'b0011, 1'b1, 4'b0011, 1'b1, 1'b0},
    {3'b011, 4'b1111, 4'b0001, 1'b0, 4'b0000, 1'b1, 1'b0},
    {3'b011, 4'b1000, 4'b1000, 1'b0, 4'b0000, 1'b1, 1'b1},
    {3'b100, 4'b1010, 4'b1111, 1'b0, 4'b0101, 1'b0, 1'b0},
    {3'b100, 4'b0110, 4'b0110, 1'b1, 4'b0000, 1'b0, 1'b0},
    {3'b101, 4'b1010, 4'b0100, 1'b0, 4'b1110, 1'b0, 1'b0},
    {3'b110, 4'b1100, 4'b1010, 1'b1, 4'b1000, 1'b0, 1'b0},
    {3'b111, 4'b0000, 4'b0000, 1'b1, 4'b1111, 1'b0, 1'b0},
    {3'b010, 4'b0011, 4'b0011, 1'b0, 4'b1111, 1'b0, 1'b0},
    {3'b010, 4'b1000, 4'b0001, 1'b1, 4'b0111, 1'b1, 1'b1}
  };
  localparam string TAG [NV] = '{"R1", "R2/R5", "R3", "R4", "R2", "R5",
    "R6", "R6", "R7", "R8", "R9", "R4", "R5"};

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {f,cout,ovr} got %b expected %b (sel=%b a=%b b=%b cin=%b)",
               req, got, exp, sel, a, b, cin);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [3:0] va, input logic [3:0] vb, input logic c);
    @(posedge clk);
    sel = s; a = va; b = vb; cin = c;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiescent state with clear code held during reset
    check("R1", {f, cout, ovr}, 6'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
      check(TAG[i], {f, cout, ovr}, VEC[i][5:0]);
    end

    // R2: full sweep of the add code
    for (int i = 0; i < 512; i++) begin
      logic [4:0] sum;
      apply(3'b011, i[3:0], i[7:4], i[8]);
      sum = {1'b0, i[3:0]} + {1'b0, i[7:4]} + {4'b0, i[8]};
      check("R2", {f, cout}, {sum[3:0], sum[4]});
    end

    // R10: non-arithmetic codes give zero flags and ignore cin
    for (int k = 0; k < 5; k++) begin
      logic [2:0] s;
      s = (k == 0) ? 3'b000 : 3'(k + 3);
      for (int i = 0; i < 256; i++) begin
        logic [5:0] r0;
        apply(s, i[3:0], i[7:4], 1'b0);
        r0 = {f, cout, ovr};
        check("R10", {cout, ovr}, 6'b0);
        apply(s, i[3:0], i[7:4], 1'b1);
        check("R10", {f, cout, ovr}, r0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule